// File: doc/BRIEF.md
# Power-Management Capability Register Block

This block holds the power-management capability of a bridge function in configuration space. It answers 32-bit configuration reads and writes at two consecutive dwords. The first is a read-only header that carries the capability identifier, the interface version and a pointer to the next capability. The second is a control/status dword that holds the current device power state and a sticky PME enable bit. A strap input picks which of two values the next-capability pointer returns.

Software moves the function between the fully working state D0 and the low-power state D3 by writing the state field. A write of either intermediate state finishes normally on the bus but changes nothing. Whenever the stored state is not D0, the block drops a gating output. The rest of the function uses that output to block interrupts and memory-mapped register traffic, and keeps accepting configuration cycles.

Top module: `pm_cap_regs`

## Requirements
- R1: After the function reset and the power-good reset, the power state is D0 (field value 00), the PME enable bit is 0 and `fn_active` is 1. A read of the control dword returns 00000000h.
- R2: A read of the header dword (dword address `HDR_DW`, default 20h) returns 01h in bits [7:0] and 010b in bits [18:16], with bits [31:19] all zero.
- R3: Header bits [15:8] read 90h when `strap_alt` is 0 and A0h when `strap_alt` is 1.
- R4: A write to the control dword (address `HDR_DW`+1) with byte enable 0 set and data bits [1:0] equal to 00 (D0) or 11 (D3) loads that value into the state field.
- R5: A write of 01 (D1) or 10 (D2) to the state field completes, but the stored state keeps its previous value.
- R6: `fn_active` is 1 exactly when the stored state is 00. It changes on the clock edge that accepts the write.
- R7: The PME enable bit is control bit 8, written through byte enable 1. The function reset does not change it, and only the power-good reset (`pg_rst_n` low) clears it.
- R8: A byte whose enable is 0 does not change any field in that byte.
- R9: In the control dword, every bit other than [1:0] and [8] reads 0. Writes to the header dword change nothing. A read of any other dword address returns 0.
- R10: Read data appears with `cfg_rd_valid` one cycle after `cfg_rd`. When a read and a write to the same dword fall in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Function reset, active low, asynchronous |
| pg_rst_n | input | 1 | Power-good reset, active low, clears the sticky bit |
| strap_alt | input | 1 | Selects the alternate next-capability pointer |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | DW_ADDR_W | Dword address of the access |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data |
| cfg_rd_valid | output | 1 | Read data valid, one cycle after `cfg_rd` |
| fn_active | output | 1 | High in D0, allows non-configuration traffic |

## Verification
A read and a write can fall in the same cycle and target the same control dword. In that case the read data must come from the stored fields before the write, and the write must still take effect in the next cycle. The bench raises both strobes in one cycle while moving the state from D0 to D3, and it also does this with a dropped D1 write. The scoreboard queues the pre-write value as the expected read. A later plain read and a check of `fn_active` then confirm the write result.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  localparam logic [7:0] CAP_ID_PM  = 8'h01;
  localparam logic [2:0] PM_VERSION = 3'b010;

  typedef struct packed {
    logic hit_hdr;
    logic hit_ctl;
  } dw_sel_t;

  // only the full-power and deepest states are accepted
  function automatic logic pstate_ok(input logic [1:0] s);
    return (s == PS_D0) || (s == PS_D3);
  endfunction

  function automatic logic [31:0] hdr_word(input logic [7:0] nxt);
    return {13'd0, PM_VERSION, nxt, CAP_ID_PM};
  endfunction

  function automatic logic [31:0] ctl_word(input logic [1:0] ps, input logic pme);
    return {23'd0, pme, 6'd0, ps};
  endfunction

endpackage

// File: rtl/pm_cap_decode.sv
module pm_cap_decode
  import pm_cap_pkg::*;
#(
  parameter int unsigned DW_ADDR_W = 6,
  parameter logic [DW_ADDR_W-1:0] HDR_DW = 6'h20
) (
  input  logic [DW_ADDR_W-1:0] dw_addr,
  output dw_sel_t              sel
);
  localparam logic [DW_ADDR_W-1:0] CTL_DW = HDR_DW + 1'b1;

  always_comb begin
    sel.hit_hdr = (dw_addr == HDR_DW);
    sel.hit_ctl = (dw_addr == CTL_DW);
  end
endmodule

// File: rtl/pm_state_reg.sv
module pm_state_reg
  import pm_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_rst_n,
  input  logic       wr_ctl,
  input  logic [1:0] wr_be,
  input  logic [1:0] wd_state,
  input  logic       wd_pme,
  output logic [1:0] pstate,
  output logic       pme_en,
  output logic       ev_take,
  output logic       ev_drop
);
  logic wr_b0;
  logic wr_b1;

  assign wr_b0   = wr_ctl && wr_be[0];
  assign wr_b1   = wr_ctl && wr_be[1];
  assign ev_take = wr_b0 && pstate_ok(wd_state);
  assign ev_drop = wr_b0 && !pstate_ok(wd_state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pstate <= PS_D0;
    else if (ev_take) pstate <= wd_state;
  end

  always_ff @(posedge clk or negedge pg_rst_n) begin
    if (!pg_rst_n) pme_en <= 1'b0;
    else if (wr_b1) pme_en <= wd_pme;
  end

  AST_TAKE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |=> pstate == $past(wd_state)); // R4
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> $stable(pstate)); // R5
  AST_NO_B0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_b0 |=> $stable(pstate)); // R8
  AST_PME_HOLD: assert property (@(posedge clk) disable iff (!pg_rst_n)
    !wr_b1 |=> $stable(pme_en)); // R7
endmodule

// File: rtl/pm_cap_readmux.sv
module pm_cap_readmux
  import pm_cap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd,
  input  dw_sel_t     sel,
  input  logic [31:0] hdr_val,
  input  logic [31:0] ctl_val,
  output logic [31:0] rdata,
  output logic        rd_valid
);
  logic [31:0] rd_next;

  always_comb begin
    rd_next = 32'd0;
    if (sel.hit_hdr) rd_next = hdr_val;
    else if (sel.hit_ctl) rd_next = ctl_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= 32'd0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd;
      if (rd) rdata <= rd_next;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !sel.hit_hdr && !sel.hit_ctl) |=> rdata == 32'd0); // R9
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pm_cap_pkg::*;
#(
  parameter int unsigned DW_ADDR_W = 6,
  parameter logic [DW_ADDR_W-1:0] HDR_DW = 6'h20,
  parameter logic [7:0] PTR_BASE = 8'h90,
  parameter logic [7:0] PTR_ALT  = 8'hA0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pg_rst_n,
  input  logic                 strap_alt,
  input  logic                 cfg_rd,
  input  logic                 cfg_wr,
  input  logic [DW_ADDR_W-1:0] cfg_dw_addr,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic                 cfg_rd_valid,
  output logic                 fn_active
);
  dw_sel_t     sel;
  logic [1:0]  pstate;
  logic        pme_en;
  logic        ev_take;
  logic        ev_drop;
  logic [7:0]  nxt_ptr;
  logic [31:0] hdr_val;
  logic [31:0] ctl_val;
  logic        unused_bits;

  assign unused_bits = ^{cfg_be[3:2], cfg_wdata[31:9], cfg_wdata[7:2]};

  pm_cap_decode #(.DW_ADDR_W(DW_ADDR_W), .HDR_DW(HDR_DW)) u_dec (
    .dw_addr (cfg_dw_addr),
    .sel     (sel)
  );

  pm_state_reg u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_rst_n (pg_rst_n),
    .wr_ctl   (cfg_wr && sel.hit_ctl),
    .wr_be    (cfg_be[1:0]),
    .wd_state (cfg_wdata[1:0]),
    .wd_pme   (cfg_wdata[8]),
    .pstate   (pstate),
    .pme_en   (pme_en),
    .ev_take  (ev_take),
    .ev_drop  (ev_drop)
  );

  assign nxt_ptr   = strap_alt ? PTR_ALT : PTR_BASE;
  assign hdr_val   = hdr_word(nxt_ptr);
  assign ctl_val   = ctl_word(pstate, pme_en);
  assign fn_active = (pstate == PS_D0);

  pm_cap_readmux u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (cfg_rd),
    .sel      (sel),
    .hdr_val  (hdr_val),
    .ctl_val  (ctl_val),
    .rdata    (cfg_rdata),
    .rd_valid (cfg_rd_valid)
  );

  AST_D3_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && cfg_wdata[1:0] == 2'b11) |=> !fn_active); // R6
  AST_D0_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && cfg_wdata[1:0] == 2'b00) |=> fn_active); // R6
  AST_HDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && sel.hit_hdr) |=> (cfg_rdata[7:0] == 8'h01 && cfg_rdata[31:16] == 16'h0002)); // R2
  AST_PTR_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && sel.hit_hdr) |=> cfg_rdata[15:8] == ($past(strap_alt) ? PTR_ALT : PTR_BASE)); // R3
  AST_CTL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && sel.hit_ctl) |=> (cfg_rdata & 32'hFFFF_FEFC) == 32'd0); // R9
endmodule

// File: tb/tb_pm_cap_regs.sv
module tb_pm_cap_regs;
  localparam int CLK_P = 10;
  localparam logic [5:0] HDR = 6'h20;
  localparam logic [5:0] CTL = 6'h21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic        cfg_rd = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dw_addr = 6'd0;
  logic [3:0]  cfg_be = 4'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        cfg_rd_valid;
  logic        fn_active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0]  m_ps = 2'b00;
  logic        m_pme = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  pm_cap_regs dut (
    .clk(clk), .rst_n(rst_n), .pg_rst_n(pg_rst_n), .strap_alt(strap_alt),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rd_valid(cfg_rd_valid),
    .fn_active(fn_active)
  );

  function automatic logic [31:0] model_read(input logic [5:0] a);
    if (a == HDR) return {13'd0, 3'b010, (strap_alt ? 8'hA0 : 8'h90), 8'h01};
    if (a == CTL) return {23'd0, m_pme, 6'd0, m_ps};
    return 32'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // one bus cycle; the read sees pre-write model state
  task automatic xact(input bit rd, input bit wr, input logic [5:0] a,
                      input logic [3:0] be, input logic [31:0] wd, input string tag);
    @(negedge clk);
    cfg_rd = rd; cfg_wr = wr; cfg_dw_addr = a; cfg_be = be; cfg_wdata = wd;
    if (rd) begin
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
    end
    if (wr && a == CTL) begin
      if (be[0] && (wd[1:0] == 2'b00 || wd[1:0] == 2'b11)) m_ps = wd[1:0];
      if (be[1]) m_pme = wd[8];
    end
    @(negedge clk);
    cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_be = 4'd0;
  endtask

  task automatic chk_active(input string tag);
    check(fn_active == (m_ps == 2'b00), tag, {31'd0, fn_active}, {31'd0, m_ps == 2'b00});
  endtask

  // monitor: pops expected read values as results appear
  always @(negedge clk) begin
    if (cfg_rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected valid", cfg_rdata, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cfg_rdata == e, t, cfg_rdata, e);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; pg_rst_n = 1'b1;
    @(negedge clk);
    chk_active("R1 reset active");
    xact(1, 0, CTL, 4'h0, 0, "R1 reset ctl");
    xact(1, 0, HDR, 4'h0, 0, "R2 R3 hdr strap0");
    strap_alt = 1'b1;
    xact(1, 0, HDR, 4'h0, 0, "R3 hdr strap1");
    strap_alt = 1'b0;
    xact(1, 0, HDR, 4'h0, 0, "R3 hdr strap back");

    // sweep from D0
    xact(0, 1, CTL, 4'h1, 32'h1, "R5 D0->D1"); chk_active("R5 D1 drop active");
    xact(0, 1, CTL, 4'h1, 32'h2, "R5 D0->D2"); chk_active("R5 D2 drop active");
    xact(1, 0, CTL, 4'h0, 0, "R5 still D0");
    xact(0, 1, CTL, 4'h1, 32'h3, "R4 D0->D3"); chk_active("R6 D3 inactive");
    xact(1, 0, CTL, 4'h0, 0, "R4 read D3");
    xact(0, 1, CTL, 4'h1, 32'h1, "R5 D3->D1"); chk_active("R5 stays D3");
    xact(0, 1, CTL, 4'h1, 32'h2, "R5 D3->D2"); chk_active("R5 stays D3 b");
    xact(1, 0, CTL, 4'h0, 0, "R5 read D3");
    xact(0, 1, CTL, 4'h1, 32'h3, "R4 D3->D3"); chk_active("R4 D3 again");
    xact(0, 1, CTL, 4'h1, 32'h0, "R4 D3->D0"); chk_active("R6 back active");
    xact(0, 1, CTL, 4'h1, 32'h0, "R4 D0->D0"); chk_active("R4 D0 again");

    // byte enables
    xact(0, 1, CTL, 4'h2, 32'h0000_0103, "R8 be1 only"); chk_active("R8 state kept");
    xact(1, 0, CTL, 4'h0, 0, "R7 R8 pme set only");
    xact(0, 1, CTL, 4'h1, 32'h0000_0000, "R8 be0 pme kept");
    xact(1, 0, CTL, 4'h0, 0, "R8 pme kept read");
    xact(0, 1, CTL, 4'hC, 32'hFFFF_FFFF, "R8 upper bytes");
    xact(1, 0, CTL, 4'h0, 0, "R8 upper no change");
    xact(0, 1, CTL, 4'hF, 32'hFFFF_FFFF, "R9 all ones");
    xact(1, 0, CTL, 4'h0, 0, "R9 reserved zero");
    chk_active("R6 all ones D3");
    xact(0, 1, HDR, 4'hF, 32'hFFFF_FFFF, "R9 hdr write");
    xact(1, 0, HDR, 4'h0, 0, "R9 hdr unchanged");
    xact(1, 0, 6'h05, 4'h0, 0, "R9 unmapped");

    // simultaneous read and write
    xact(0, 1, CTL, 4'h1, 32'h0, "R10 to D0");
    xact(1, 1, CTL, 4'h1, 32'h3, "R10 rd+wr D0->D3");
    chk_active("R10 write landed");
    xact(1, 1, CTL, 4'h1, 32'h1, "R10 rd+wr dropped D1");
    xact(1, 0, CTL, 4'h0, 0, "R10 after same-cycle");

    // function reset keeps sticky bit
    @(negedge clk); rst_n = 1'b0; m_ps = 2'b00;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_active("R7 fn reset to D0");
    xact(1, 0, CTL, 4'h0, 0, "R7 pme survives fn reset");
    @(negedge clk); pg_rst_n = 1'b0; m_pme = 1'b0;
    @(negedge clk); pg_rst_n = 1'b1;
    xact(1, 0, CTL, 4'h0, 0, "R7 pg reset clears pme");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule